// File: doc/BRIEF.md
# Single-Entry Address-Space-Tagged Translation Cache

This block holds one cached virtual-to-physical translation for a 39-bit, three-level paged virtual address space. The stored entry has an address-space tag, a global flag, the virtual address, the physical address, the page-table entry word, the physical address the entry was read from, and the page level. The page level sets the page size: 4 KiB, 2 MiB or 1 GiB.

A combinational lookup port takes an address-space tag and a virtual address. It returns a hit flag, the translated physical address, the stored entry word and the entry's own physical address. Three requests act on the clock edge:
- A fill replaces the entry.
- An entry-word update rewrites only the stored word, for example after accessed or dirty bits are set.
- A flush, with an optional tag and an optional address, invalidates the entry when it matches.

The page-table walk and the permission checks live outside this block.

Top module: `single_tlb`

## Requirements
- R1: While reset is active, and after it until the first fill, every lookup misses, and `lk_paddr_o`, `lk_pte_o` and `lk_pte_addr_o` are all zero.
- R2: A fill, when no flush is requested in the same cycle, replaces every stored field with the fill inputs and marks the entry valid from the next cycle.
- R3: A lookup hits only when three conditions hold: the entry is valid, the virtual address bits above the page mask equal the stored ones, and either the stored global flag is 1 or the lookup tag equals the stored tag.
- R4: The page mask is (1 << (12 + 9*level)) - 1 over the 39 address bits. Levels 0, 1 and 2 give 12, 21 and 30 offset bits. Level 3 gives all 39 bits.
- R5: On a hit, `lk_paddr_o` equals the stored physical address ORed with the zero-extended (lookup address AND page mask). `lk_pte_o` and `lk_pte_addr_o` carry the stored values. On a miss, all three outputs are zero.
- R6: An entry-word update, with no fill and no flush in the same cycle, replaces only the stored entry word. The tag, global flag, addresses, level and validity are kept.
- R7: In a flush, an absent tag (`fl_asid_vld_i`=0) matches any entry. A present tag matches only an entry whose global flag is 0 and whose tag is equal.
- R8: In a flush, an absent address (`fl_addr_vld_i`=0) matches any address. A present address matches when its bits above the stored entry's page mask equal the stored address bits.
- R9: A flush that matches a valid entry empties it. A flush that does not match leaves every stored field unchanged.
- R10: A flush request blocks any fill and any entry-word update in the same cycle. When a fill and an update arrive together without a flush, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_asid_i | input | 16 | Lookup address-space tag |
| lk_vaddr_i | input | 39 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 56 | Translated physical address (zero on miss) |
| lk_pte_o | output | 64 | Stored entry word (zero on miss) |
| lk_pte_addr_o | output | 56 | Physical address of the entry word (zero on miss) |
| fill_en_i | input | 1 | Fill request |
| fill_asid_i | input | 16 | Fill tag |
| fill_global_i | input | 1 | Fill global flag |
| fill_vaddr_i | input | 39 | Fill virtual address |
| fill_paddr_i | input | 56 | Fill physical address (page base) |
| fill_pte_i | input | 64 | Fill entry word |
| fill_pte_addr_i | input | 56 | Fill entry-word physical address |
| fill_level_i | input | 2 | Fill page level, 0 = 4 KiB |
| upd_en_i | input | 1 | Entry-word update request |
| upd_pte_i | input | 64 | New entry word |
| fl_en_i | input | 1 | Flush request |
| fl_asid_vld_i | input | 1 | Flush tag present |
| fl_asid_i | input | 16 | Flush tag |
| fl_addr_vld_i | input | 1 | Flush address present |
| fl_vaddr_i | input | 39 | Flush virtual address |

## Verification
The hardest cases to reach are those where two rules meet. One is a global entry hit by a tagged flush that must leave it alone. Another is a superpage entry probed with addresses that differ only in bits just inside or just outside its mask. The bench reaches these with a directed sequence that refills the entry at each of the four levels, flips single address bits at bit 12, 21, 30 and 38, and issues tagged flushes against global and non-global entries. After that, a long random phase draws tags from a two-value set and addresses from two bases with single-bit perturbations. This keeps hits, boundary misses and same-cycle fill, update and flush collisions frequent.

// File: rtl/single_tlb_pkg.sv
package single_tlb_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_FILL = 2'd1,
    WR_PTE  = 2'd2,
    WR_KILL = 2'd3
  } wr_op_e;
endpackage

// File: rtl/single_tlb_mask.sv
module single_tlb_mask #(
  parameter int VA_W     = 39,
  parameter int LVL_W    = 2,
  parameter int PG_OFS_W = 12,
  parameter int LVL_BITS = 9
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [VA_W-1:0]  mask_o
);
  localparam int NLVL = 1 << LVL_W;

  logic [VA_W-1:0] cand [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int SH = PG_OFS_W + g * LVL_BITS;
    if (SH >= VA_W) begin : g_full
      assign cand[g] = {VA_W{1'b1}};
    end else begin : g_part
      assign cand[g] = VA_W'((64'd1 << SH) - 64'd1);
    end
  end

  assign mask_o = cand[level_i];
endmodule

// File: rtl/single_tlb_cmp.sv
module single_tlb_cmp #(
  parameter int ASID_W = 16,
  parameter int VA_W   = 39
) (
  input  logic              v_i,
  input  logic              g_i,
  input  logic [ASID_W-1:0] e_asid_i,
  input  logic [VA_W-1:0]   e_vaddr_i,
  input  logic [VA_W-1:0]   mask_i,
  input  logic              asid_chk_i,
  input  logic              glob_wild_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              addr_chk_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic              hit_o
);
  logic asid_eq, asid_ok, vpn_eq, addr_ok;

  assign asid_eq = (asid_i == e_asid_i);
  // lookup: global waives the tag; flush: global refuses a tagged match
  assign asid_ok = !asid_chk_i || (glob_wild_i ? (g_i || asid_eq) : (!g_i && asid_eq));
  assign vpn_eq  = ((vaddr_i ^ e_vaddr_i) & ~mask_i) == '0;
  assign addr_ok = !addr_chk_i || vpn_eq;
  assign hit_o   = v_i && asid_ok && addr_ok;
endmodule

// File: rtl/single_tlb_entry.sv
module single_tlb_entry
  import single_tlb_pkg::*;
#(
  parameter int ASID_W = 16,
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PTE_W  = 64,
  parameter int LVL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_op_e            op_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              global_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [PA_W-1:0]   paddr_i,
  input  logic [PTE_W-1:0]  fill_pte_i,
  input  logic [PA_W-1:0]   pte_addr_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [PTE_W-1:0]  upd_pte_i,
  output logic              v_o,
  output logic [ASID_W-1:0] asid_o,
  output logic              global_o,
  output logic [VA_W-1:0]   vaddr_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [PTE_W-1:0]  pte_o,
  output logic [PA_W-1:0]   pte_addr_o,
  output logic [LVL_W-1:0]  level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
    end else if (op_i == WR_FILL) begin
      v_o <= 1'b1;
    end else if (op_i == WR_KILL) begin
      v_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asid_o     <= '0;
      global_o   <= 1'b0;
      vaddr_o    <= '0;
      paddr_o    <= '0;
      pte_addr_o <= '0;
      level_o    <= '0;
    end else if (op_i == WR_FILL) begin
      asid_o     <= asid_i;
      global_o   <= global_i;
      vaddr_o    <= vaddr_i;
      paddr_o    <= paddr_i;
      pte_addr_o <= pte_addr_i;
      level_o    <= level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pte_o <= '0;
    end else if (op_i == WR_FILL) begin
      pte_o <= fill_pte_i;
    end else if (op_i == WR_PTE) begin
      pte_o <= upd_pte_i;
    end
  end
endmodule

// File: rtl/single_tlb.sv
module single_tlb
  import single_tlb_pkg::*;
#(
  parameter int ASID_W   = 16,
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PTE_W    = 64,
  parameter int LVL_W    = 2,
  parameter int PG_OFS_W = 12,
  parameter int LVL_BITS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic [PTE_W-1:0]  lk_pte_o,
  output logic [PA_W-1:0]   lk_pte_addr_o,
  input  logic              fill_en_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i,
  input  logic [VA_W-1:0]   fill_vaddr_i,
  input  logic [PA_W-1:0]   fill_paddr_i,
  input  logic [PTE_W-1:0]  fill_pte_i,
  input  logic [PA_W-1:0]   fill_pte_addr_i,
  input  logic [LVL_W-1:0]  fill_level_i,
  input  logic              upd_en_i,
  input  logic [PTE_W-1:0]  upd_pte_i,
  input  logic              fl_en_i,
  input  logic              fl_asid_vld_i,
  input  logic [ASID_W-1:0] fl_asid_i,
  input  logic              fl_addr_vld_i,
  input  logic [VA_W-1:0]   fl_vaddr_i
);
  logic              e_v, e_g;
  logic [ASID_W-1:0] e_asid;
  logic [VA_W-1:0]   e_vaddr;
  logic [PA_W-1:0]   e_paddr, e_pte_addr;
  logic [PTE_W-1:0]  e_pte;
  logic [LVL_W-1:0]  e_level;
  logic [VA_W-1:0]   e_mask;
  logic              lk_hit, fl_hit;
  wr_op_e            op;

  single_tlb_mask #(
    .VA_W(VA_W), .LVL_W(LVL_W), .PG_OFS_W(PG_OFS_W), .LVL_BITS(LVL_BITS)
  ) i_mask (
    .level_i(e_level),
    .mask_o (e_mask)
  );

  single_tlb_cmp #(.ASID_W(ASID_W), .VA_W(VA_W)) i_lk_cmp (
    .v_i        (e_v),
    .g_i        (e_g),
    .e_asid_i   (e_asid),
    .e_vaddr_i  (e_vaddr),
    .mask_i     (e_mask),
    .asid_chk_i (1'b1),
    .glob_wild_i(1'b1),
    .asid_i     (lk_asid_i),
    .addr_chk_i (1'b1),
    .vaddr_i    (lk_vaddr_i),
    .hit_o      (lk_hit)
  );

  single_tlb_cmp #(.ASID_W(ASID_W), .VA_W(VA_W)) i_fl_cmp (
    .v_i        (e_v),
    .g_i        (e_g),
    .e_asid_i   (e_asid),
    .e_vaddr_i  (e_vaddr),
    .mask_i     (e_mask),
    .asid_chk_i (fl_asid_vld_i),
    .glob_wild_i(1'b0),
    .asid_i     (fl_asid_i),
    .addr_chk_i (fl_addr_vld_i),
    .vaddr_i    (fl_vaddr_i),
    .hit_o      (fl_hit)
  );

  // flush owns the cycle; fill beats update
  always_comb begin
    op = WR_NONE;
    if (fl_en_i) begin
      if (fl_hit) op = WR_KILL;
    end else if (fill_en_i) begin
      op = WR_FILL;
    end else if (upd_en_i) begin
      op = WR_PTE;
    end
  end

  single_tlb_entry #(
    .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .LVL_W(LVL_W)
  ) i_entry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .asid_i    (fill_asid_i),
    .global_i  (fill_global_i),
    .vaddr_i   (fill_vaddr_i),
    .paddr_i   (fill_paddr_i),
    .fill_pte_i(fill_pte_i),
    .pte_addr_i(fill_pte_addr_i),
    .level_i   (fill_level_i),
    .upd_pte_i (upd_pte_i),
    .v_o       (e_v),
    .asid_o    (e_asid),
    .global_o  (e_g),
    .vaddr_o   (e_vaddr),
    .paddr_o   (e_paddr),
    .pte_o     (e_pte),
    .pte_addr_o(e_pte_addr),
    .level_o   (e_level)
  );

  assign lk_hit_o      = lk_hit;
  assign lk_paddr_o    = lk_hit ? (e_paddr | PA_W'(lk_vaddr_i & e_mask)) : '0;
  assign lk_pte_o      = lk_hit ? e_pte : '0;
  assign lk_pte_addr_o = lk_hit ? e_pte_addr : '0;
endmodule

// File: rtl/single_tlb_chk.sv
module single_tlb_chk #(
  parameter int VA_W  = 39,
  parameter int PTE_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fill_en_i,
  input logic             upd_en_i,
  input logic [PTE_W-1:0] upd_pte_i,
  input logic             fl_en_i,
  input logic             fl_hit,
  input logic             lk_hit_o,
  input logic             e_v,
  input logic [VA_W-1:0]  e_vaddr,
  input logic [PTE_W-1:0] e_pte
);
  p_empty_miss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e_v |-> !lk_hit_o);

  p_fill_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !fl_en_i) |=> e_v);

  p_upd_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !fill_en_i && !fl_en_i) |=> (e_pte == $past(upd_pte_i)));

  p_flush_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_en_i && fl_hit) |=> !e_v);

  p_flush_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_en_i && !fl_hit) |=> ($stable(e_v) && $stable(e_pte)));

  p_flush_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_en_i |=> $stable(e_vaddr));
endmodule

bind single_tlb single_tlb_chk #(.VA_W(VA_W), .PTE_W(PTE_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fill_en_i(fill_en_i),
  .upd_en_i (upd_en_i),
  .upd_pte_i(upd_pte_i),
  .fl_en_i  (fl_en_i),
  .fl_hit   (fl_hit),
  .lk_hit_o (lk_hit_o),
  .e_v      (e_v),
  .e_vaddr  (e_vaddr),
  .e_pte    (e_pte)
);

// File: tb/test_single_tlb.sv
module test_single_tlb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lk_asid = '0;
  logic [38:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [55:0] lk_paddr, lk_pte_addr;
  logic [63:0] lk_pte;
  logic        fill_en = 0, fill_global = 0;
  logic [15:0] fill_asid = '0;
  logic [38:0] fill_vaddr = '0;
  logic [55:0] fill_paddr = '0, fill_pte_addr = '0;
  logic [63:0] fill_pte = '0;
  logic [1:0]  fill_level = '0;
  logic        upd_en = 0;
  logic [63:0] upd_pte = '0;
  logic        fl_en = 0, fl_asid_vld = 0, fl_addr_vld = 0;
  logic [15:0] fl_asid = '0;
  logic [38:0] fl_vaddr = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit          m_v = 0, m_g = 0;
  logic [15:0] m_asid = '0;
  logic [38:0] m_va = '0;
  logic [55:0] m_pa = '0, m_pta = '0;
  logic [63:0] m_pte = '0;
  logic [1:0]  m_lvl = '0;

  always #2 clk = ~clk;

  single_tlb i_single_tlb (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_asid_i(lk_asid), .lk_vaddr_i(lk_vaddr), .lk_hit_o(lk_hit),
    .lk_paddr_o(lk_paddr), .lk_pte_o(lk_pte), .lk_pte_addr_o(lk_pte_addr),
    .fill_en_i(fill_en), .fill_asid_i(fill_asid), .fill_global_i(fill_global),
    .fill_vaddr_i(fill_vaddr), .fill_paddr_i(fill_paddr), .fill_pte_i(fill_pte),
    .fill_pte_addr_i(fill_pte_addr), .fill_level_i(fill_level),
    .upd_en_i(upd_en), .upd_pte_i(upd_pte),
    .fl_en_i(fl_en), .fl_asid_vld_i(fl_asid_vld), .fl_asid_i(fl_asid),
    .fl_addr_vld_i(fl_addr_vld), .fl_vaddr_i(fl_vaddr)
  );

  function automatic logic [38:0] msk(logic [1:0] l);
    int sh = 12 + 9 * int'(l);
    if (sh >= 39) return '1;
    return (39'd1 << sh) - 39'd1;
  endfunction

  function automatic bit vpn_same(logic [38:0] a, logic [38:0] b, logic [1:0] l);
    return ((a ^ b) & ~msk(l)) == '0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit h;
    h = m_v && vpn_same(lk_vaddr, m_va, m_lvl) && (m_g || lk_asid == m_asid);
    chk({tag, " hit"}, 64'(lk_hit), 64'(h));
    chk({tag, " paddr"}, 64'(lk_paddr), h ? 64'(m_pa | 56'(lk_vaddr & msk(m_lvl))) : 64'd0);
    chk({tag, " pte"}, lk_pte, h ? m_pte : 64'd0);
    chk({tag, " pte_addr"}, 64'(lk_pte_addr), h ? 64'(m_pta) : 64'd0);
  endtask

  task automatic model_edge();
    bit fm;
    fm = m_v && (!fl_asid_vld || (!m_g && fl_asid == m_asid))
             && (!fl_addr_vld || vpn_same(fl_vaddr, m_va, m_lvl));
    if (fl_en) begin
      if (fm) m_v = 0;
    end else if (fill_en) begin
      m_v = 1; m_g = fill_global; m_asid = fill_asid; m_va = fill_vaddr;
      m_pa = fill_paddr; m_pta = fill_pte_addr; m_pte = fill_pte; m_lvl = fill_level;
    end else if (upd_en) begin
      m_pte = upd_pte;
    end
  endtask

  task automatic step(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fill_en = 0; upd_en = 0; fl_en = 0;
  endtask

  task automatic look(logic [15:0] a, logic [38:0] v, string tag);
    lk_asid = a; lk_vaddr = v; step(tag);
  endtask

  task automatic fill(logic [15:0] a, bit g, logic [38:0] v, logic [1:0] l,
                      logic [55:0] p, logic [63:0] t, logic [55:0] ta);
    fill_en = 1; fill_asid = a; fill_global = g; fill_vaddr = v; fill_level = l;
    fill_paddr = p; fill_pte = t; fill_pte_addr = ta;
  endtask

  task automatic flush(bit av, logic [15:0] a, bit vv, logic [38:0] v);
    fl_en = 1; fl_asid_vld = av; fl_asid = a; fl_addr_vld = vv; fl_vaddr = v;
  endtask

  localparam logic [38:0] V0 = 39'h12_3456_7000;
  localparam logic [38:0] V1 = 39'h40_0800_0000;

  initial begin
    @(negedge clk);
    look(16'd5, V0, "R1 in reset");
    look(16'd0, 39'd0, "R1 in reset");
    @(negedge clk) rst_ni = 1'b1;
    look(16'd5, V0, "R1 after reset");

    fill(16'd5, 0, V0, 2'd0, 56'hAB_CDEF_0000_0000, 64'h1111, 56'h8000);
    step("R2 fill");
    look(16'd5, V0 | 39'habc, "R5 hit paddr");
    look(16'd6, V0, "R3 tag mismatch");
    look(16'd5, V0 ^ 39'h1000, "R4 level0 bit12");

    fill(16'd5, 0, V0, 2'd1, 56'h12_0000_0000, 64'h2222, 56'h8008);
    step("R2 refill");
    look(16'd5, V0 ^ 39'h1000, "R4 level1 inside");
    look(16'd5, V0 ^ 39'h20_0000, "R4 level1 outside");
    fill(16'd5, 0, V0, 2'd2, 56'h40_0000_0000, 64'h3333, 56'h8010);
    step("R2 refill");
    look(16'd5, V0 ^ 39'h2000_0000, "R4 level2 inside");
    look(16'd5, V0 ^ 39'h4000_0000, "R4 level2 outside");
    fill(16'd5, 0, V0, 2'd3, 56'h0, 64'h4444, 56'h8018);
    step("R2 refill");
    look(16'd5, V0 ^ 39'h40_0000_0000, "R4 level3 all");

    upd_en = 1; upd_pte = 64'hDEAD_BEEF; step("R6 update");
    look(16'd5, V0, "R6 word only");

    flush(1, 16'd6, 0, '0); step("R9 flush miss");
    look(16'd5, V0, "R9 unchanged");
    flush(1, 16'd5, 0, '0); step("R7 flush tag");
    look(16'd5, V0, "R7 emptied");

    fill(16'd5, 1, V1, 2'd0, 56'h77_0000, 64'h5555, 56'h9000);
    step("R2 global fill");
    look(16'd9, V1, "R3 global any tag");
    flush(1, 16'd5, 0, '0); step("R7 global tagged flush");
    look(16'd9, V1, "R7 global kept");
    flush(0, '0, 1, V1 ^ 39'h1000); step("R8 addr mismatch");
    look(16'd9, V1, "R8 kept");
    flush(0, '0, 1, V1 | 39'h123); step("R8 addr match");
    look(16'd9, V1, "R8 emptied");

    fill(16'd5, 0, V0, 2'd0, 56'h1000, 64'h6666, 56'hA000);
    flush(1, 16'd3, 0, '0); step("R10 fill blocked");
    look(16'd5, V0, "R10 still empty");
    fill(16'd5, 0, V0, 2'd0, 56'h1000, 64'h6666, 56'hA000);
    upd_en = 1; upd_pte = 64'h7777; step("R10 fill beats update");
    look(16'd5, V0, "R10 fill word");

    for (int i = 0; i < 4000; i++) begin
      logic [38:0] base, pert;
      int r;
      r = int'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: pert = 39'($urandom_range(0, 4095));
        1: pert = 39'h1000;
        2: pert = 39'h20_0000;
        3: pert = 39'h4000_0000;
        4: pert = 39'h40_0000_0000;
        default: pert = '0;
      endcase
      base = $urandom_range(0, 1) ? V0 : V1;
      lk_asid = 16'($urandom_range(1, 2));
      lk_vaddr = base ^ pert;
      if (r == 0)
        fill(16'($urandom_range(1, 2)), 1'($urandom_range(0, 1)), base,
             2'($urandom_range(0, 3)), {24'($urandom), 32'($urandom)},
             {$urandom, $urandom}, {24'($urandom), 32'($urandom)});
      if (r == 1) begin upd_en = 1; upd_pte = {$urandom, $urandom}; end
      if (r == 2 || r == 3)
        flush(1'($urandom_range(0, 1)), 16'($urandom_range(1, 2)),
              1'($urandom_range(0, 1)), (($urandom_range(0, 1) != 0) ? V0 : V1) ^ pert);
      if (r == 4) begin
        fill(16'd1, 0, base, 2'($urandom_range(0, 3)), 56'h5000, 64'h99, 56'h40);
        upd_en = 1; upd_pte = 64'h1;
        if ($urandom_range(0, 1) != 0) flush(0, '0, 0, '0);
      end
      step("random R3 R5 R9 R10");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule